// File: doc/BRIEF.md
# Radio Frame Timer with Event Strobes

This block keeps the frame timing of a radio link in the link's byte clock domain. A physical-layer timer counts clocks up to a programmable terminal value and then counts a frame. Three radio timers (main, uplink and downlink) each keep a clock count, a symbol index and a frame count. The clock terminal value of a radio timer is read from a 16-entry symbol-length table at the timer's current symbol index. The table is walked from index 0 up to a programmable last index, so frames built from symbols of unequal length can be described. The uplink and downlink copies differ from the main timer only by the init values they load on a sync pulse. This gives the fixed displacement between the three timelines.

A bank of event generators turns timer boundaries into strobes. Each generator watches one selected boundary: the symbol or frame boundary of one of the three radio timers. On that boundary it waits a programmable offset. It then fires, and it repeats every modulo clocks until the next boundary restarts it. A modulo of zero gives a single strobe per boundary. All settings are written through a simple address/data write port.

Top module: `radio_frame_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every counter reads 0, no event output is high, and every event source reads 7 (disabled).
- R2: The physical timer clock count goes from 0 up to the terminal value at address 0x11 (reset value PHY_TC_DEF). On the cycle after it reaches that value it returns to 0 and the physical frame count increments modulo 2^FRM_W. The physical frame strobe is high exactly while the clock count is 0.
- R3: A radio timer's clock count runs from 0 up to table entry [symbol index]. Entry i is at address 0x00+i. When it reaches that entry it returns to 0 on the next cycle and the symbol index advances by one.
- R4: When the clock count wraps with the symbol index at or above the last index (address 0x10), the symbol index returns to 0 and the frame count increments modulo 2^FRM_W. A timer's symbol strobe is high while its clock count is 0. Its frame strobe is high while both its clock count and its symbol index are 0.
- R5: Timers 0, 1 and 2 (main, uplink, downlink) follow identical rules. Each takes its own init clock count, symbol index and frame count from addresses 0x20+4t, 0x21+4t and 0x22+4t.
- R6: A sync pulse loads every radio timer from its init values, and clears the physical timer, on the next clock edge.
- R7: Event e is configured at 0x40+4e (offset), 0x41+4e (modulo) and 0x42+4e (source). If its selected strobe is high in cycle t, the event output is high in cycle t+1+offset.
- R8: With a non-zero modulo M, the event output fires again every M cycles after its first firing, until the next selected strobe.
- R9: With modulo 0 the event fires exactly once per selected strobe.
- R10: The source field selects strobes as follows: 0 main symbol, 1 main frame, 2 uplink symbol, 3 uplink frame, 4 downlink symbol, 5 downlink frame. Values 6 and 7 hold the event idle, so it never fires.
- R11: A selected strobe restarts the offset countdown in any state. A sync pulse restarts the countdown only of events still waiting out their offset.
- R12: A clock count above the current terminal value, or a symbol index above the last index (for example after an init load), wraps on the next cycle as if it were at the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Reload all timers from init values |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data (low bits used) |
| phy_clk_cnt | output | CLK_W | Physical timer clock count |
| phy_frm_cnt | output | FRM_W | Physical timer frame count |
| phy_frm_strobe | output | 1 | Physical frame boundary |
| tmr_clk_cnt | output | 3 x CLK_W | Clock count of main, uplink, downlink timers |
| tmr_sym_cnt | output | 3 x IDX_W | Symbol index of each radio timer |
| tmr_frm_cnt | output | 3 x FRM_W | Frame count of each radio timer |
| tmr_sym_strobe | output | 3 | Symbol boundary of each radio timer |
| tmr_frm_strobe | output | 3 | Frame boundary of each radio timer |
| evt_out | output | NUM_EVT | Event strobes |

## Verification
The bench builds the block with CLK_W=16, FRM_W=8, NUM_EVT=4 and PHY_TC_DEF=49. A 50-clock physical frame then wraps many times in a short run, and the 8-bit frame counts are exercised. With four events, the bench runs repeating, single-shot, disabled and offset-longer-than-symbol generators at the same time. Symbol tables of three unequal symbols keep frames 13 clocks long. Init values above the table limits are loaded on purpose, to reach the wrap rule of R12.

// File: rtl/rft_pkg.sv
package rft_pkg;
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_DELAY  = 2'd1,
        EV_REPEAT = 2'd2
    } ev_state_e;

    localparam int NUM_RAD = 3;
    localparam int SRC_W   = 3;
    localparam int NUM_SRC = 2 * NUM_RAD;

    localparam logic [7:0] A_LUT_BASE  = 8'h00;
    localparam logic [7:0] A_LAST_IDX  = 8'h10;
    localparam logic [7:0] A_PHY_TC    = 8'h11;
    localparam logic [7:0] A_INIT_BASE = 8'h20;
    localparam logic [7:0] A_EVT_BASE  = 8'h40;
endpackage

// File: rtl/rft_regs.sv
module rft_regs
    import rft_pkg::*;
#(
    parameter int CLK_W      = 22,
    parameter int FRM_W      = 12,
    parameter int LUT_DEPTH  = 16,
    parameter int NUM_EVT    = 8,
    parameter int PHY_TC_DEF = 2457599,
    localparam int IDX_W     = $clog2(LUT_DEPTH)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [7:0]                           wr_addr,
    input  logic [31:0]                          wr_data,
    output logic [LUT_DEPTH-1:0][CLK_W-1:0]      lut_tc,
    output logic [IDX_W-1:0]                     last_idx,
    output logic [CLK_W-1:0]                     phy_tc,
    output logic [NUM_RAD-1:0][CLK_W-1:0]        init_clk,
    output logic [NUM_RAD-1:0][IDX_W-1:0]        init_sym,
    output logic [NUM_RAD-1:0][FRM_W-1:0]        init_frm,
    output logic [NUM_EVT-1:0][CLK_W-1:0]        ev_off,
    output logic [NUM_EVT-1:0][CLK_W-1:0]        ev_mod,
    output logic [NUM_EVT-1:0][SRC_W-1:0]        ev_src
);
    logic [IDX_W-1:0] last_q;
    logic [CLK_W-1:0] phy_tc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q   <= '0;
            phy_tc_q <= CLK_W'(PHY_TC_DEF);
        end else if (wr_en) begin
            if (wr_addr == A_LAST_IDX) last_q   <= wr_data[IDX_W-1:0];
            if (wr_addr == A_PHY_TC)   phy_tc_q <= wr_data[CLK_W-1:0];
        end
    end

    assign last_idx = last_q;
    assign phy_tc   = phy_tc_q;

    for (genvar i = 0; i < LUT_DEPTH; i++) begin : g_lut
        localparam logic [7:0] ADR = A_LUT_BASE + 8'(i);
        logic [CLK_W-1:0] tc_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        tc_q <= '0;
            else if (wr_en && wr_addr == ADR)  tc_q <= wr_data[CLK_W-1:0];
        end
        assign lut_tc[i] = tc_q;
    end

    for (genvar t = 0; t < NUM_RAD; t++) begin : g_init
        localparam logic [7:0] ADR = A_INIT_BASE + 8'(4 * t);
        logic [CLK_W-1:0] clk_q;
        logic [IDX_W-1:0] sym_q;
        logic [FRM_W-1:0] frm_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                clk_q <= '0;
                sym_q <= '0;
                frm_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADR)        clk_q <= wr_data[CLK_W-1:0];
                if (wr_addr == ADR + 8'd1) sym_q <= wr_data[IDX_W-1:0];
                if (wr_addr == ADR + 8'd2) frm_q <= wr_data[FRM_W-1:0];
            end
        end
        assign init_clk[t] = clk_q;
        assign init_sym[t] = sym_q;
        assign init_frm[t] = frm_q;
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        localparam logic [7:0] ADR = A_EVT_BASE + 8'(4 * e);
        logic [CLK_W-1:0] off_q;
        logic [CLK_W-1:0] mod_q;
        logic [SRC_W-1:0] src_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_q <= '0;
                mod_q <= '0;
                src_q <= '1;
            end else if (wr_en) begin
                if (wr_addr == ADR)        off_q <= wr_data[CLK_W-1:0];
                if (wr_addr == ADR + 8'd1) mod_q <= wr_data[CLK_W-1:0];
                if (wr_addr == ADR + 8'd2) src_q <= wr_data[SRC_W-1:0];
            end
        end
        assign ev_off[e] = off_q;
        assign ev_mod[e] = mod_q;
        assign ev_src[e] = src_q;
    end
endmodule

// File: rtl/rft_phy_cnt.sv
module rft_phy_cnt #(
    parameter int CLK_W = 22,
    parameter int FRM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [CLK_W-1:0] tc,
    output logic [CLK_W-1:0] clk_cnt,
    output logic [FRM_W-1:0] frm_cnt,
    output logic             frm_strobe
);
    logic [CLK_W-1:0] clk_q;
    logic [FRM_W-1:0] frm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= '0;
            frm_q <= '0;
        end else if (sync) begin
            clk_q <= '0;
            frm_q <= '0;
        end else if (clk_q >= tc) begin
            clk_q <= '0;
            frm_q <= frm_q + 1'b1;
        end else begin
            clk_q <= clk_q + 1'b1;
        end
    end

    assign clk_cnt    = clk_q;
    assign frm_cnt    = frm_q;
    assign frm_strobe = (clk_q == '0);
endmodule

// File: rtl/rft_radio_cnt.sv
module rft_radio_cnt #(
    parameter int CLK_W     = 22,
    parameter int FRM_W     = 12,
    parameter int LUT_DEPTH = 16,
    localparam int IDX_W    = $clog2(LUT_DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sync,
    input  logic [LUT_DEPTH-1:0][CLK_W-1:0] lut_tc,
    input  logic [IDX_W-1:0]                last_idx,
    input  logic [CLK_W-1:0]                init_clk,
    input  logic [IDX_W-1:0]                init_sym,
    input  logic [FRM_W-1:0]                init_frm,
    output logic [CLK_W-1:0]                clk_cnt,
    output logic [IDX_W-1:0]                sym_cnt,
    output logic [FRM_W-1:0]                frm_cnt,
    output logic                            sym_strobe,
    output logic                            frm_strobe
);
    logic [CLK_W-1:0] clk_q;
    logic [IDX_W-1:0] sym_q;
    logic [FRM_W-1:0] frm_q;
    logic [CLK_W-1:0] cur_tc;
    logic             sym_end;
    logic             frm_end;

    assign cur_tc  = lut_tc[sym_q];
    assign sym_end = (clk_q >= cur_tc);
    assign frm_end = sym_end && (sym_q >= last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= '0;
            sym_q <= '0;
            frm_q <= '0;
        end else if (sync) begin
            clk_q <= init_clk;
            sym_q <= init_sym;
            frm_q <= init_frm;
        end else if (frm_end) begin
            clk_q <= '0;
            sym_q <= '0;
            frm_q <= frm_q + 1'b1;
        end else if (sym_end) begin
            clk_q <= '0;
            sym_q <= sym_q + 1'b1;
        end else begin
            clk_q <= clk_q + 1'b1;
        end
    end

    assign clk_cnt    = clk_q;
    assign sym_cnt    = sym_q;
    assign frm_cnt    = frm_q;
    assign sym_strobe = (clk_q == '0);
    assign frm_strobe = (clk_q == '0) && (sym_q == '0);
endmodule

// File: rtl/rft_event.sv
module rft_event
    import rft_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync,
    input  logic [NUM_SRC-1:0] src_strobe,
    input  logic [CNT_W-1:0]   offset,
    input  logic [CNT_W-1:0]   modulo,
    input  logic [SRC_W-1:0]   src_sel,
    output logic               fire
);
    localparam int PAD_W = 2 ** SRC_W;

    ev_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PAD_W-1:0] strobe_pad;
    logic             src_valid;
    logic             trig;
    logic             at_zero;

    assign strobe_pad = PAD_W'(src_strobe);
    assign src_valid  = (32'(src_sel) < NUM_SRC);
    assign trig       = src_valid && strobe_pad[src_sel];
    assign at_zero    = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!src_valid) begin
            state_d = EV_IDLE;
            cnt_d   = '0;
        end else if (trig) begin
            state_d = EV_DELAY;
            cnt_d   = offset;
        end else begin
            unique case (state_q)
                EV_IDLE: begin
                    cnt_d = cnt_q;
                end
                EV_DELAY: begin
                    if (sync) begin
                        cnt_d = offset;
                    end else if (!at_zero) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (modulo == '0) begin
                        state_d = EV_IDLE;
                    end else begin
                        state_d = EV_REPEAT;
                        cnt_d   = modulo - 1'b1;
                    end
                end
                EV_REPEAT: begin
                    if (!at_zero) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (modulo == '0) begin
                        state_d = EV_IDLE;
                    end else begin
                        cnt_d = modulo - 1'b1;
                    end
                end
                default: begin
                    state_d = EV_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        fire = (state_q != EV_IDLE) && at_zero;
    end
endmodule

// File: rtl/radio_frame_timer.sv
module radio_frame_timer
    import rft_pkg::*;
#(
    parameter int CLK_W      = 22,
    parameter int FRM_W      = 12,
    parameter int LUT_DEPTH  = 16,
    parameter int NUM_EVT    = 8,
    parameter int PHY_TC_DEF = 2457599,
    localparam int IDX_W     = $clog2(LUT_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sync,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_addr,
    input  logic [31:0]                   wr_data,
    output logic [CLK_W-1:0]              phy_clk_cnt,
    output logic [FRM_W-1:0]              phy_frm_cnt,
    output logic                          phy_frm_strobe,
    output logic [NUM_RAD-1:0][CLK_W-1:0] tmr_clk_cnt,
    output logic [NUM_RAD-1:0][IDX_W-1:0] tmr_sym_cnt,
    output logic [NUM_RAD-1:0][FRM_W-1:0] tmr_frm_cnt,
    output logic [NUM_RAD-1:0]            tmr_sym_strobe,
    output logic [NUM_RAD-1:0]            tmr_frm_strobe,
    output logic [NUM_EVT-1:0]            evt_out
);
    logic [LUT_DEPTH-1:0][CLK_W-1:0] lut_tc;
    logic [IDX_W-1:0]                last_idx;
    logic [CLK_W-1:0]                phy_tc;
    logic [NUM_RAD-1:0][CLK_W-1:0]   init_clk;
    logic [NUM_RAD-1:0][IDX_W-1:0]   init_sym;
    logic [NUM_RAD-1:0][FRM_W-1:0]   init_frm;
    logic [NUM_EVT-1:0][CLK_W-1:0]   ev_off;
    logic [NUM_EVT-1:0][CLK_W-1:0]   ev_mod;
    logic [NUM_EVT-1:0][SRC_W-1:0]   ev_src;
    logic [NUM_SRC-1:0]              src_strobe;

    rft_regs #(
        .CLK_W(CLK_W), .FRM_W(FRM_W), .LUT_DEPTH(LUT_DEPTH),
        .NUM_EVT(NUM_EVT), .PHY_TC_DEF(PHY_TC_DEF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lut_tc(lut_tc), .last_idx(last_idx), .phy_tc(phy_tc),
        .init_clk(init_clk), .init_sym(init_sym), .init_frm(init_frm),
        .ev_off(ev_off), .ev_mod(ev_mod), .ev_src(ev_src)
    );

    rft_phy_cnt #(.CLK_W(CLK_W), .FRM_W(FRM_W)) u_phy (
        .clk(clk), .rst_n(rst_n), .sync(sync), .tc(phy_tc),
        .clk_cnt(phy_clk_cnt), .frm_cnt(phy_frm_cnt), .frm_strobe(phy_frm_strobe)
    );

    for (genvar t = 0; t < NUM_RAD; t++) begin : g_rad
        rft_radio_cnt #(.CLK_W(CLK_W), .FRM_W(FRM_W), .LUT_DEPTH(LUT_DEPTH)) u_cnt (
            .clk(clk), .rst_n(rst_n), .sync(sync),
            .lut_tc(lut_tc), .last_idx(last_idx),
            .init_clk(init_clk[t]), .init_sym(init_sym[t]), .init_frm(init_frm[t]),
            .clk_cnt(tmr_clk_cnt[t]), .sym_cnt(tmr_sym_cnt[t]), .frm_cnt(tmr_frm_cnt[t]),
            .sym_strobe(tmr_sym_strobe[t]), .frm_strobe(tmr_frm_strobe[t])
        );
        assign src_strobe[2*t]   = tmr_sym_strobe[t];
        assign src_strobe[2*t+1] = tmr_frm_strobe[t];
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        rft_event #(.CNT_W(CLK_W)) u_evt (
            .clk(clk), .rst_n(rst_n), .sync(sync), .src_strobe(src_strobe),
            .offset(ev_off[e]), .modulo(ev_mod[e]), .src_sel(ev_src[e]),
            .fire(evt_out[e])
        );
    end
endmodule

// File: rtl/rft_checker.sv
module rft_checker
    import rft_pkg::*;
#(
    parameter int CLK_W = 22,
    parameter int FRM_W = 12,
    parameter int IDX_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sync,
    input logic [CLK_W-1:0]              phy_clk_cnt,
    input logic [FRM_W-1:0]              phy_frm_cnt,
    input logic [NUM_RAD-1:0][CLK_W-1:0] tmr_clk_cnt,
    input logic [NUM_RAD-1:0][IDX_W-1:0] tmr_sym_cnt,
    input logic [NUM_RAD-1:0][FRM_W-1:0] tmr_frm_cnt,
    input logic [NUM_RAD-1:0]            tmr_sym_strobe,
    input logic [NUM_RAD-1:0]            tmr_frm_strobe
);
    AST_PHY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (phy_clk_cnt == '0) || (phy_clk_cnt == $past(phy_clk_cnt) + 1'b1)); // R2
    AST_PHY_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (phy_clk_cnt == '0) || (phy_frm_cnt == $past(phy_frm_cnt))); // R2
    AST_SYNC_PHY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (phy_clk_cnt == '0) && (phy_frm_cnt == '0)); // R6

    for (genvar t = 0; t < NUM_RAD; t++) begin : g_chk
        AST_RAD_CLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !sync |=> (tmr_clk_cnt[t] == '0) || (tmr_clk_cnt[t] == $past(tmr_clk_cnt[t]) + 1'b1)); // R3
        AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !sync |=> (tmr_clk_cnt[t] == '0) || (tmr_sym_cnt[t] == $past(tmr_sym_cnt[t]))); // R3
        AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !sync |=> ((tmr_clk_cnt[t] == '0) && (tmr_sym_cnt[t] == '0))
                      || (tmr_frm_cnt[t] == $past(tmr_frm_cnt[t]))); // R4
        AST_FRM_IN_SYM: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_frm_strobe[t] |-> tmr_sym_strobe[t]); // R4
    end
endmodule

bind radio_frame_timer rft_checker #(
    .CLK_W(CLK_W), .FRM_W(FRM_W), .IDX_W(IDX_W)
) u_rft_chk (
    .clk(clk), .rst_n(rst_n), .sync(sync),
    .phy_clk_cnt(phy_clk_cnt), .phy_frm_cnt(phy_frm_cnt),
    .tmr_clk_cnt(tmr_clk_cnt), .tmr_sym_cnt(tmr_sym_cnt), .tmr_frm_cnt(tmr_frm_cnt),
    .tmr_sym_strobe(tmr_sym_strobe), .tmr_frm_strobe(tmr_frm_strobe)
);

// File: tb/radio_frame_timer_test.sv
`timescale 1ns/1ps
module radio_frame_timer_test;
    localparam int CW = 16;
    localparam int FW = 8;
    localparam int LD = 16;
    localparam int NE = 4;
    localparam int IW = 4;
    localparam int NR = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sync = 1'b0;
    logic                 wr_en = 1'b0;
    logic [7:0]           wr_addr = '0;
    logic [31:0]          wr_data = '0;
    logic [CW-1:0]        phy_clk_cnt;
    logic [FW-1:0]        phy_frm_cnt;
    logic                 phy_frm_strobe;
    logic [NR-1:0][CW-1:0] tmr_clk_cnt;
    logic [NR-1:0][IW-1:0] tmr_sym_cnt;
    logic [NR-1:0][FW-1:0] tmr_frm_cnt;
    logic [NR-1:0]        tmr_sym_strobe;
    logic [NR-1:0]        tmr_frm_strobe;
    logic [NE-1:0]        evt_out;

    radio_frame_timer #(
        .CLK_W(CW), .FRM_W(FW), .LUT_DEPTH(LD), .NUM_EVT(NE), .PHY_TC_DEF(49)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sync(sync), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .phy_clk_cnt(phy_clk_cnt), .phy_frm_cnt(phy_frm_cnt),
        .phy_frm_strobe(phy_frm_strobe), .tmr_clk_cnt(tmr_clk_cnt),
        .tmr_sym_cnt(tmr_sym_cnt), .tmr_frm_cnt(tmr_frm_cnt),
        .tmr_sym_strobe(tmr_sym_strobe), .tmr_frm_strobe(tmr_frm_strobe),
        .evt_out(evt_out)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    string phase = "R1";

    // behavioural reference state
    int m_pc, m_pf, m_phytc, m_last;
    int m_c[NR], m_s[NR], m_f[NR];
    int m_ic[NR], m_is[NR], m_if[NR];
    int m_lut[LD];
    int m_eo[NE], m_em[NE], m_es[NE], m_est[NE], m_ecnt[NE];
    int m_strb[6];

    task automatic model_reset();
        m_pc = 0; m_pf = 0; m_phytc = 49; m_last = 0;
        for (int t = 0; t < NR; t++) begin
            m_c[t] = 0; m_s[t] = 0; m_f[t] = 0; m_ic[t] = 0; m_is[t] = 0; m_if[t] = 0;
        end
        for (int i = 0; i < LD; i++) m_lut[i] = 0;
        for (int e = 0; e < NE; e++) begin
            m_eo[e] = 0; m_em[e] = 0; m_es[e] = 7; m_est[e] = 0; m_ecnt[e] = 0;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int t = 0; t < NR; t++) begin
                m_strb[2*t]   = (m_c[t] == 0) ? 1 : 0;
                m_strb[2*t+1] = (m_c[t] == 0 && m_s[t] == 0) ? 1 : 0;
            end
            // events: 0 idle, 1 waiting offset, 2 repeating
            for (int e = 0; e < NE; e++) begin
                if (m_es[e] > 5) begin
                    m_est[e] = 0; m_ecnt[e] = 0;
                end else if (m_strb[m_es[e]] != 0) begin
                    m_est[e] = 1; m_ecnt[e] = m_eo[e];
                end else if (m_est[e] == 1) begin
                    if (sync) m_ecnt[e] = m_eo[e];
                    else if (m_ecnt[e] > 0) m_ecnt[e]--;
                    else if (m_em[e] == 0) m_est[e] = 0;
                    else begin m_est[e] = 2; m_ecnt[e] = m_em[e] - 1; end
                end else if (m_est[e] == 2) begin
                    if (m_ecnt[e] > 0) m_ecnt[e]--;
                    else if (m_em[e] == 0) m_est[e] = 0;
                    else m_ecnt[e] = m_em[e] - 1;
                end
            end
            if (sync) begin
                m_pc = 0; m_pf = 0;
            end else if (m_pc >= m_phytc) begin
                m_pc = 0; m_pf = (m_pf + 1) % 256;
            end else m_pc++;
            for (int t = 0; t < NR; t++) begin
                if (sync) begin
                    m_c[t] = m_ic[t]; m_s[t] = m_is[t]; m_f[t] = m_if[t];
                end else if (m_c[t] >= m_lut[m_s[t]]) begin
                    m_c[t] = 0;
                    if (m_s[t] >= m_last) begin
                        m_s[t] = 0; m_f[t] = (m_f[t] + 1) % 256;
                    end else m_s[t]++;
                end else m_c[t]++;
            end
            if (wr_en) begin
                int a, d;
                a = int'(wr_addr); d = int'(wr_data);
                if (a < LD) m_lut[a] = d & 16'hFFFF;
                if (a == 16) m_last = d & 15;
                if (a == 17) m_phytc = d & 16'hFFFF;
                for (int t = 0; t < NR; t++) begin
                    if (a == 32 + 4*t) m_ic[t] = d & 16'hFFFF;
                    if (a == 33 + 4*t) m_is[t] = d & 15;
                    if (a == 34 + 4*t) m_if[t] = d & 255;
                end
                for (int e = 0; e < NE; e++) begin
                    if (a == 64 + 4*e) m_eo[e] = d & 16'hFFFF;
                    if (a == 65 + 4*e) m_em[e] = d & 16'hFFFF;
                    if (a == 66 + 4*e) m_es[e] = d & 7;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s (phase %s) actual=%0d expected=%0d", tag, what, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R2", "phy clock count", int'(phy_clk_cnt), m_pc);
            chk("R2", "phy frame count", int'(phy_frm_cnt), m_pf);
            chk("R2", "phy frame strobe", int'(phy_frm_strobe), (m_pc == 0) ? 1 : 0);
            for (int t = 0; t < NR; t++) begin
                chk((t == 0) ? "R3" : "R5", $sformatf("timer%0d clock", t), int'(tmr_clk_cnt[t]), m_c[t]);
                chk((t == 0) ? "R3" : "R5", $sformatf("timer%0d symbol", t), int'(tmr_sym_cnt[t]), m_s[t]);
                chk((t == 0) ? "R4" : "R5", $sformatf("timer%0d frame", t), int'(tmr_frm_cnt[t]), m_f[t]);
                chk("R4", $sformatf("timer%0d symbol strobe", t), int'(tmr_sym_strobe[t]), (m_c[t] == 0) ? 1 : 0);
                chk("R4", $sformatf("timer%0d frame strobe", t), int'(tmr_frm_strobe[t]),
                    (m_c[t] == 0 && m_s[t] == 0) ? 1 : 0);
            end
            for (int e = 0; e < NE; e++)
                chk("R7", $sformatf("event%0d", e), int'(evt_out[e]),
                    (m_est[e] != 0 && m_ecnt[e] == 0) ? 1 : 0);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        // R1: reset values observed while reset is held and just after
        run(3);
        chk("R1", "event0 source at reset", m_es[0], 7);
        @(negedge clk) rst_n = 1'b1;
        chk("R1", "events idle after reset", int'(evt_out), 0);
        // R2: default physical terminal value, then a smaller one
        phase = "R2";
        run(120);
        wr(17, 9);
        run(40);
        // R3, R4: three unequal symbols, last index 2
        phase = "R3";
        wr(0, 3); wr(1, 5); wr(2, 2); wr(16, 2);
        run(60);
        // R5, R6: displaced uplink and downlink timelines
        phase = "R6";
        wr(36, 2); wr(37, 1); wr(38, 5);
        wr(40, 4); wr(41, 2); wr(42, 10);
        pulse_sync();
        run(40);
        // R7, R8: repeating event on main frame boundary
        phase = "R8";
        wr(64, 3); wr(65, 4); wr(66, 1);
        run(60);
        // R9: single shot on uplink symbols; R10: disabled source 6
        phase = "R9";
        wr(68, 1); wr(69, 0); wr(70, 2);
        wr(72, 0); wr(73, 1); wr(74, 6);
        run(60);
        // R11: offset longer than a symbol restarts on each strobe, sync restarts delay
        phase = "R11";
        wr(76, 20); wr(77, 0); wr(78, 4);
        run(30);
        pulse_sync();
        run(7);
        pulse_sync();
        run(50);
        wr(78, 5);
        run(40);
        // R10: source 7 also idle
        phase = "R10";
        wr(66, 7);
        run(30);
        // R12: init values beyond the table and last index
        phase = "R12";
        wr(9, 0); wr(32, 30); wr(33, 9); wr(34, 255);
        pulse_sync();
        run(40);
        wr(17, 3);
        run(20);
        finish_run();
    end
endmodule